// File: doc/BRIEF.md
# Selectable Test Baseband Pattern Generator

This block produces a serial baseband bit stream for driving a modulator during bring-up and test. A three-bit mode input picks one of five patterns: a steady 0, a steady 1, an alternating 0/1 stream, a maximal-length sequence of period 7, or a maximal-length sequence of period 15. A bit-rate enable sets the pace. The pattern advances by one bit on each clock cycle in which the enable is high, and it holds while the enable is low.

Each emitted bit comes with a valid strobe. A frame marker flags the first bit of every pattern period, so a downstream symbol mapper or a scope trigger can align to the pattern. The period is 1 for the two constant modes, 2 for the alternating mode, and 7 or 15 for the pseudo-random modes. Changing the mode restarts the newly chosen pattern from its first bit.

Top module: `bbp_pattern_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, the next clock edge drives `ser_bit`, `bit_vld` and `frame_start` to 0. The first enabled bit after reset is the first bit of the selected pattern, with `frame_start` high.
- R2: `bit_vld` is 1 in the cycle after a cycle with `bit_en` high, and 0 in the cycle after a cycle with `bit_en` low. In the cycle after a cycle with `bit_en` low, `frame_start` is 0 and `ser_bit` keeps its previous value, and the pattern position does not advance.
- R3: Mode 0 (and the unused codes 5, 6 and 7) emits a steady 0. Its period is one bit, so `frame_start` is high on every valid bit.
- R4: Mode 1 emits a steady 1. Its period is one bit, so `frame_start` is high on every valid bit.
- R5: Mode 2 emits 0,1,0,1,... starting with 0. `frame_start` is high on each 0.
- R6: Mode 3 emits the period-7 sequence 0,0,1,0,1,1,1 from a 3-bit shift register with polynomial x^3+x^2+1 and seed 001. The output is the register MSB; the register shifts toward the MSB and takes in MSB xor bit 1. `frame_start` marks the seed state.
- R7: Mode 4 emits the period-15 sequence 0,0,0,1,0,0,1,1,0,1,0,1,1,1,1 from a 4-bit shift register with polynomial x^4+x^3+1 and seed 0001. The output is the register MSB; the register shifts toward the MSB and takes in bit 3 xor bit 2. `frame_start` marks the seed state.
- R8: Any change of `mode` restarts the pattern at its first bit. This holds whether the change arrives in an enabled cycle or while `bit_en` is low. The next valid bit carries `frame_start`.
- R9: In the two shift-register modes the register never holds the all-zero state after one cycle in a stable mode. An all-zero state is replaced by the seed before it is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate enable; one bit is emitted per enabled cycle |
| mode | input | 3 | Pattern select: 0 zeros, 1 ones, 2 alternating, 3 period-7, 4 period-15, 5-7 zeros |
| ser_bit | output | 1 | Serial pattern bit |
| bit_vld | output | 1 | High for one cycle for each emitted bit |
| frame_start | output | 1 | High with the first bit of each pattern period |

## Verification
Every output is registered once. The bit, valid strobe and frame marker for an enabled cycle therefore appear at the edge that closes that cycle. They can be read half a clock later. The bench drives `bit_en` and `mode` on the falling edge and samples all three outputs on the next falling edge, which is exactly one rising edge later. A mode change is modelled as a position reset that shows on the first valid bit after it, however many idle cycles come between. A reset shows as cleared outputs on the falling edge after the first reset edge.

// File: rtl/bbp_pkg.sv
package bbp_pkg;

    localparam int MODE_W  = 3;
    localparam int STATE_W = 4;
    localparam int SHORT_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_ZERO = 3'd0,
        PM_ONE  = 3'd1,
        PM_ALT  = 3'd2,
        PM_M7   = 3'd3,
        PM_M15  = 3'd4
    } pat_mode_e;

    typedef logic [STATE_W-1:0] pat_state_t;

    localparam pat_state_t SEED_SHIFT = pat_state_t'(1);
    localparam pat_state_t SEED_PLAIN = '0;

    typedef struct packed {
        logic bit_val;
        logic frame;
    } emit_t;

    typedef struct packed {
        logic ser;
        logic vld;
        logic frame;
    } out_t;

    function automatic logic is_shift_mode(input logic [MODE_W-1:0] m);
        return (m == PM_M7) || (m == PM_M15);
    endfunction

    function automatic pat_state_t seed_of(input logic [MODE_W-1:0] m);
        return is_shift_mode(m) ? SEED_SHIFT : SEED_PLAIN;
    endfunction

    function automatic pat_state_t advance(input logic [MODE_W-1:0] m,
                                           input pat_state_t s);
        pat_state_t n;
        n = s;
        case (m)
            PM_ALT:  n = {{(STATE_W-1){1'b0}}, ~s[0]};
            PM_M7:   n = {1'b0, s[SHORT_W-2:0], s[SHORT_W-1] ^ s[SHORT_W-2]};
            PM_M15:  n = {s[STATE_W-2:0], s[STATE_W-1] ^ s[STATE_W-2]};
            default: n = s;
        endcase
        return n;
    endfunction

    function automatic logic bit_of(input logic [MODE_W-1:0] m,
                                    input pat_state_t s);
        logic b;
        case (m)
            PM_ONE:  b = 1'b1;
            PM_ALT:  b = s[0];
            PM_M7:   b = s[SHORT_W-1];
            PM_M15:  b = s[STATE_W-1];
            default: b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bbp_mode_watch.sv
module bbp_mode_watch
    import bbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    output logic              restart
);
    logic [MODE_W-1:0] mode_last;
    logic              after_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_last <= '0;
            after_rst <= 1'b1;
        end else begin
            mode_last <= mode;
            after_rst <= 1'b0;
        end
    end

    assign restart = after_rst || (mode != mode_last);
endmodule

// File: rtl/bbp_seq_engine.sv
module bbp_seq_engine
    import bbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              restart,
    input  logic              bit_en,
    output pat_state_t        state_q,
    output emit_t             emit
);
    pat_state_t seed;
    pat_state_t cur;
    logic       stuck;

    assign seed  = seed_of(mode);
    assign stuck = is_shift_mode(mode) && (state_q == '0);
    assign cur   = (restart || stuck) ? seed : state_q;

    always_comb begin
        emit.bit_val = bit_of(mode, cur);
        emit.frame   = (cur == seed);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED_SHIFT;
        else if (bit_en)
            state_q <= advance(mode, cur);
        else
            state_q <= cur;
    end
endmodule

// File: rtl/bbp_out_reg.sv
module bbp_out_reg
    import bbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  emit_t emit,
    output out_t  out_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld   <= bit_en;
            out_q.frame <= bit_en && emit.frame;
            if (bit_en)
                out_q.ser <= emit.bit_val;
        end
    end
endmodule

// File: rtl/bbp_pattern_gen.sv
module bbp_pattern_gen
    import bbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic [2:0] mode,
    output logic       ser_bit,
    output logic       bit_vld,
    output logic       frame_start
);
    logic       restart;
    pat_state_t eng_state;
    emit_t      emit;
    out_t       out_q;

    bbp_mode_watch u_watch (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .restart (restart)
    );

    bbp_seq_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .restart (restart),
        .bit_en  (bit_en),
        .state_q (eng_state),
        .emit    (emit)
    );

    bbp_out_reg u_out (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .emit   (emit),
        .out_q  (out_q)
    );

    assign ser_bit     = out_q.ser;
    assign bit_vld     = out_q.vld;
    assign frame_start = out_q.frame;
endmodule

// File: rtl/bbp_pattern_chk.sv
module bbp_pattern_chk
    import bbp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [2:0] mode,
    input logic       ser_bit,
    input logic       bit_vld,
    input logic       frame_start,
    input logic [3:0] eng_state
);
    logic [2:0] mode_d;
    logic       hist_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_d  <= '0;
            hist_ok <= 1'b0;
        end else begin
            mode_d  <= mode;
            hist_ok <= 1'b1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!ser_bit && !bit_vld && !frame_start));

    // R2
    vld_follows_en_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> bit_vld);

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> (!bit_vld && !frame_start && $stable(ser_bit)));

    // R3
    zero_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && (mode == 3'd0 || mode >= 3'd5)) |=> (!ser_bit && frame_start));

    // R4
    one_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && mode == 3'd1) |=> (ser_bit && frame_start));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && bit_en && mode != mode_d) |=> frame_start);

    // R9
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && mode == mode_d && is_shift_mode(mode)) |-> (eng_state != 4'd0));

    // R2
    frame_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> bit_vld);
endmodule

bind bbp_pattern_gen bbp_pattern_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .mode        (mode),
    .ser_bit     (ser_bit),
    .bit_vld     (bit_vld),
    .frame_start (frame_start),
    .eng_state   (eng_state)
);

// File: tb/bbp_pattern_gen_test.sv
module bbp_pattern_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       ser_bit, bit_vld, frame_start;

    int checks = 0;
    int failures = 0;
    int pos = 0;
    logic last_bit = 1'b0;

    always #10 clk = ~clk;

    bbp_pattern_gen uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .mode(mode),
        .ser_bit(ser_bit), .bit_vld(bit_vld), .frame_start(frame_start)
    );

    function automatic int period_of(input logic [2:0] m);
        case (m)
            3'd1: return 1;
            3'd2: return 2;
            3'd3: return 7;
            3'd4: return 15;
            default: return 1;
        endcase
    endfunction

    // Reference bit at position k, computed from the polynomials in R5..R7.
    function automatic logic ref_bit(input logic [2:0] m, input int k);
        logic [3:0] s;
        s = 4'b0001;
        case (m)
            3'd1: return 1'b1;
            3'd2: return logic'(k % 2);
            3'd3: begin
                for (int i = 0; i < k % 7; i++) s = {1'b0, s[1:0], s[2] ^ s[1]};
                return s[2];
            end
            3'd4: begin
                for (int i = 0; i < k % 15; i++) s = {s[2:0], s[3] ^ s[2]};
                return s[3];
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, sample on the next falling edge.
    task automatic step(input logic en, input string req);
        logic eb;
        bit_en = en;
        @(negedge clk);
        if (en) begin
            eb = ref_bit(mode, pos);
            check("R2", "bit_vld", bit_vld, 1'b1);
            check(req, "ser_bit", ser_bit, eb);
            check(req, "frame_start", frame_start, (pos % period_of(mode)) == 0);
            last_bit = eb;
            pos++;
        end else begin
            check("R2", "idle bit_vld", bit_vld, 1'b0);
            check("R2", "idle frame_start", frame_start, 1'b0);
            check("R2", "idle ser_bit hold", ser_bit, last_bit);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode = m;
        pos = 0;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: outputs cleared under reset
        check("R1", "reset ser_bit", ser_bit, 1'b0);
        check("R1", "reset bit_vld", bit_vld, 1'b0);
        check("R1", "reset frame_start", frame_start, 1'b0);
        rst = 1'b0;
        last_bit = 1'b0;

        // Sweep every mode code with a gapped enable pattern (R3..R7).
        for (int m = 0; m < 8; m++) begin
            set_mode(3'(m));
            for (int i = 0; i < 40; i++) step((i % 4) != 3, req_of(3'(m)));
        end

        // R8: mode change while enable low, first valid bit restarts.
        set_mode(3'd4);
        for (int i = 0; i < 6; i++) step(1'b1, "R7");
        set_mode(3'd3);
        step(1'b0, "R8");
        step(1'b0, "R8");
        for (int i = 0; i < 9; i++) step(1'b1, "R8");

        // R8: change back in an enabled cycle mid-period.
        set_mode(3'd4);
        for (int i = 0; i < 17; i++) step(1'b1, "R8");
        set_mode(3'd2);
        for (int i = 0; i < 3; i++) step(1'b1, "R8");

        // R1: reset mid-run restarts the pattern.
        set_mode(3'd3);
        for (int i = 0; i < 4; i++) step(1'b1, "R6");
        rst = 1'b1;
        bit_en = 1'b1;
        @(negedge clk);
        check("R1", "mid reset ser_bit", ser_bit, 1'b0);
        check("R1", "mid reset bit_vld", bit_vld, 1'b0);
        check("R1", "mid reset frame_start", frame_start, 1'b0);
        rst = 1'b0;
        pos = 0;
        last_bit = 1'b0;
        for (int i = 0; i < 8; i++) step(1'b1, "R1");

        // R7: long run over several periods, no gaps.
        set_mode(3'd4);
        for (int i = 0; i < 47; i++) step(1'b1, "R7");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule